// File: doc/BRIEF.md
# Triggered Capture Buffer Controller

This block sits between a 16-bit two's-complement ADC, an external linear SRAM and a host. It supports three operating modes. In hardware capture, every ADC sample-ready strobe that arrives while the trigger is active stores one word in the SRAM at the running address. In read-back, the host drains the stored words one at a time. In direct read, the host takes the most recent ADC sample straight from the converter path. The trigger and ready inputs are asynchronous, and each one passes through a two-flop synchroniser before it is used.

One address counter serves both capture and read-back. The host clears it with a synchronous counter-run input, which is active-high; driving it low clears the counter. Capture stops when the counter reaches the selected record length. At that point a stop flag is raised and held. The stop flag is a plain level, so it can drive the trigger of a second unit built with the active-high trigger option, and the two units then capture back to back. Stored words stay in the SRAM until a new capture writes over them.

Host data leaves on a valid/ready stream. The block holds `rd_valid_o` and `rd_data_o` steady until the host raises `rd_ready_i`. A word transfers on a clock edge where both are high. The host can hold off for any number of cycles; nothing is lost, and the address does not move.

Top module: `adc_capture_ctrl`

## Requirements
- R1: After reset, `stop_o`, `sram_we_o` and `rd_valid_o` are 0 and `sram_addr_o` is 0.
- R2: `mode_i` selects the mode: 0 idle, 1 capture, 2 read-back, 3 direct. The outputs {`adc_oe_o`,`adc_pwr_o`,`sram_oe_o`,`sram_cs_o`} are 0000 in idle, 1100 in capture, 0011 in read-back and 1100 in direct, whenever no write is in progress.
- R3: In capture mode, each rising edge of the synchronised ready input produces exactly one SRAM write. The write occurs only while the trigger is active, `cnt_run_i` is 1 and `stop_o` is 0. `sram_we_o` is high for one clock, and the address advances by one after it.
- R4: Holding `cnt_run_i` low clears the address to 0 and clears `stop_o` on the next clock edge.
- R5: `len_sel_i` selects the record length in words: 0 gives LEN_SMALL, 1 gives LEN_MID, and 2 or 3 give LEN_LARGE. The write that brings the address to the selected length sets `stop_o`. Further strobes produce no write.
- R6: Parameter TRIG_ACTIVE_HIGH selects the trigger polarity. A unit built active-low behaves identically to an active-high unit when it is fed the inverted trigger.
- R7: Once set, `stop_o` stays high, whatever the trigger or strobe activity, until `cnt_run_i` goes low.
- R8: In read-back mode with `cnt_run_i` high, the behaviour is as follows:
  - `rd_valid_o` is 1 while the address is below the selected length.
  - `rd_data_o` carries the SRAM word at the current address.
  - Each handshake advances the address by one.
  - While `rd_ready_i` is low, the address does not change.
- R9: In direct mode, each ready strobe latches the ADC word and raises `rd_valid_o`. The word stays valid until a handshake takes it.
- R10: Sample values pass through both paths bit-exact, including the full-scale values 0x7FFF and 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode select (0 idle, 1 capture, 2 read-back, 3 direct) |
| cnt_run_i | input | 1 | Counter run; low clears the address and the stop flag |
| len_sel_i | input | 2 | Record length select |
| trig_i | input | 1 | Asynchronous capture trigger |
| adc_rdy_i | input | 1 | Asynchronous ADC sample-ready strobe |
| adc_data_i | input | DATA_W | ADC sample, two's complement |
| adc_oe_o | output | 1 | ADC output enable |
| adc_pwr_o | output | 1 | ADC power enable |
| sram_cs_o | output | 1 | SRAM chip select |
| sram_we_o | output | 1 | SRAM write enable, one clock per sample |
| sram_oe_o | output | 1 | SRAM output enable |
| sram_addr_o | output | ADDR_W | SRAM word address |
| sram_wdata_o | output | DATA_W | SRAM write data |
| sram_rdata_i | input | DATA_W | SRAM read data, valid for the current address |
| rd_valid_o | output | 1 | Host stream valid |
| rd_ready_i | input | 1 | Host stream ready |
| rd_data_o | output | DATA_W | Host stream data |
| stop_o | output | 1 | Record-full stop flag, usable as a chained trigger |

## Verification
The hardest situation to reach is a completely full record followed by more strobes. Reaching it means keeping the trigger active for the whole length and also dropping strobes inside a trigger gap. The stimulus therefore runs captures with more strobes than the record holds, and it deasserts the trigger over a fixed window part-way through each capture. Sample values are random and include both full-scale words. Read-back then drains each record under random back-pressure, so the data, the exact word count and the end-of-record valid drop are all checked against the bench's own list of accepted samples.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE     = 2'd0,
    MODE_CAPTURE  = 2'd1,
    MODE_READBACK = 2'd2,
    MODE_DIRECT   = 2'd3
  } cap_mode_e;

  typedef struct packed {
    logic adc_oe;
    logic adc_pwr;
    logic sram_rd;
  } mode_ctl_t;

  function automatic mode_ctl_t decode_mode(cap_mode_e m);
    mode_ctl_t c;
    c = '0;
    unique case (m)
      MODE_CAPTURE:  begin c.adc_oe = 1'b1; c.adc_pwr = 1'b1; end
      MODE_READBACK: begin c.sram_rd = 1'b1; end
      MODE_DIRECT:   begin c.adc_oe = 1'b1; c.adc_pwr = 1'b1; end
      default:       c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cap_addr_ctr.sv
module cap_addr_ctr #(
  parameter int CNT_W = 23,
  parameter int LEN_S = 262144,
  parameter int LEN_M = 2097152,
  parameter int LEN_L = 4194304
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             wr_adv_i,
  input  logic [1:0]       len_sel_i,
  output logic [CNT_W-2:0] addr_o,
  output logic             at_len_o,
  output logic             stop_o
);
  localparam logic [CNT_W-1:0] LenS = CNT_W'(LEN_S);
  localparam logic [CNT_W-1:0] LenM = CNT_W'(LEN_M);
  localparam logic [CNT_W-1:0] LenL = CNT_W'(LEN_L);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, len_w;
  logic             stop_q;

  always_comb begin
    unique case (len_sel_i)
      2'd0:    len_w = LenS;
      2'd1:    len_w = LenM;
      default: len_w = LenL;
    endcase
  end

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (adv_i) begin
      cnt_q <= cnt_nxt;
      if (wr_adv_i && (cnt_nxt >= len_w)) stop_q <= 1'b1;
    end
  end

  assign addr_o   = cnt_q[CNT_W-2:0];
  assign at_len_o = (cnt_q >= len_w);
  assign stop_o   = stop_q;
endmodule

// File: rtl/cap_writer.sv
module cap_writer #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_o <= fire_i;
      if (fire_i) wdata_o <= sample_i;
    end
  end
endmodule

// File: rtl/cap_host_rd.sv
module cap_host_rd
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cap_mode_e         mode_i,
  input  logic              cnt_run_i,
  input  logic              at_len_i,
  input  logic              busy_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] sram_rdata_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rb_adv_o
);
  logic              fresh_q;
  logic [DATA_W-1:0] sample_q;
  logic              rb_valid, dir_valid;

  assign rb_valid  = (mode_i == MODE_READBACK) && cnt_run_i && !at_len_i && !busy_i;
  assign dir_valid = (mode_i == MODE_DIRECT) && fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q  <= 1'b0;
      sample_q <= '0;
    end else if (mode_i != MODE_DIRECT) begin
      fresh_q <= 1'b0;
    end else if (strobe_i) begin
      fresh_q  <= 1'b1;
      sample_q <= sample_i;
    end else if (dir_valid && rd_ready_i) begin
      fresh_q <= 1'b0;
    end
  end

  assign rd_valid_o = rb_valid || dir_valid;
  assign rd_data_o  = (mode_i == MODE_READBACK) ? sram_rdata_i : sample_q;
  assign rb_adv_o   = rb_valid && rd_ready_i;
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DATA_W           = 16,
  parameter int ADDR_W           = 22,
  parameter int LEN_SMALL        = 262144,
  parameter int LEN_MID          = 2097152,
  parameter int LEN_LARGE        = 4194304,
  parameter bit TRIG_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              cnt_run_i,
  input  logic [1:0]        len_sel_i,
  input  logic              trig_i,
  input  logic              adc_rdy_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_oe_o,
  output logic              adc_pwr_o,
  output logic              sram_cs_o,
  output logic              sram_we_o,
  output logic              sram_oe_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stop_o
);
  localparam int CNT_W = ADDR_W + 1;

  cap_mode_e mode_w;
  mode_ctl_t ctl_w;
  logic      trig_s, rdy_s, rdy_d, trig_act, strobe, fire;
  logic      at_len, rb_adv, we_w, stop_w;

  assign mode_w = cap_mode_e'(mode_i);
  assign ctl_w  = decode_mode(mode_w);

  cap_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({trig_i, adc_rdy_i}),
    .q_o   ({trig_s, rdy_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_d <= 1'b0;
    else         rdy_d <= rdy_s;
  end
  assign strobe = rdy_s && !rdy_d;

  generate
    if (TRIG_ACTIVE_HIGH) begin : g_trig_hi
      assign trig_act = trig_s;
    end else begin : g_trig_lo
      assign trig_act = !trig_s;
    end
  endgenerate

  assign fire = strobe && (mode_w == MODE_CAPTURE) && cnt_run_i
                && !stop_w && !at_len && trig_act;

  cap_writer #(.DATA_W(DATA_W)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .sample_i(adc_data_i),
    .we_o    (we_w),
    .wdata_o (sram_wdata_o)
  );

  cap_addr_ctr #(
    .CNT_W(CNT_W), .LEN_S(LEN_SMALL), .LEN_M(LEN_MID), .LEN_L(LEN_LARGE)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!cnt_run_i),
    .adv_i    (we_w || rb_adv),
    .wr_adv_i (we_w),
    .len_sel_i(len_sel_i),
    .addr_o   (sram_addr_o),
    .at_len_o (at_len),
    .stop_o   (stop_w)
  );

  cap_host_rd #(.DATA_W(DATA_W)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_w),
    .cnt_run_i   (cnt_run_i),
    .at_len_i    (at_len),
    .busy_i      (we_w),
    .strobe_i    (strobe),
    .sample_i    (adc_data_i),
    .sram_rdata_i(sram_rdata_i),
    .rd_ready_i  (rd_ready_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .rb_adv_o    (rb_adv)
  );

  assign adc_oe_o  = ctl_w.adc_oe;
  assign adc_pwr_o = ctl_w.adc_pwr;
  assign sram_we_o = we_w;
  assign sram_oe_o = ctl_w.sram_rd && !we_w;
  assign sram_cs_o = ctl_w.sram_rd || we_w;
  assign stop_o    = stop_w;
endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              cnt_run_i,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic              sram_we_o,
  input logic              sram_oe_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              stop_o
);
  a_r3_we_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |=> !sram_we_o);

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_o && cnt_run_i) |=> (sram_addr_o == $past(sram_addr_o) + 1'b1));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_run_i |=> (sram_addr_o == '0 && !stop_o));

  a_r5_stop_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> $past(sram_we_o));

  a_r7_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && cnt_run_i) |=> stop_o);

  a_r2_no_drive_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_we_o && sram_oe_o));

  a_r8_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && rd_valid_o && !rd_ready_i) |=> $stable(sram_addr_o));

  a_r9_direct_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && rd_valid_o && !rd_ready_i) |=> (rd_valid_o || mode_i != 2'd3));
endmodule

bind adc_capture_ctrl cap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .cnt_run_i  (cnt_run_i),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .sram_we_o  (sram_we_o),
  .sram_oe_o  (sram_oe_o),
  .sram_addr_o(sram_addr_o),
  .stop_o     (stop_o)
);

// File: tb/adc_capture_ctrl_tb_top.sv
module adc_capture_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int L_S = 8;
  localparam int L_M = 32;
  localparam int L_L = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic cnt_run = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic trig = 1'b0;
  logic rdy = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic rd_ready = 1'b0;

  logic adc_oe, adc_pwr, cs, we, oe, rd_valid, stop;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata, rd_data;
  logic lo_oe, lo_pwr, lo_cs, lo_we, lo_soe, lo_valid, lo_stop;
  logic [AW-1:0] lo_addr;
  logic [DW-1:0] lo_wdata, lo_rd_data;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] exp_q [0:(1<<AW)-1];
  int wr_count = 0;
  int lo_mism = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rdata = mem[addr];
  always @(posedge clk) begin
    if (we && cs) mem[addr] <= wdata;
    if (we) wr_count <= wr_count + 1;
  end
  always @(negedge clk)
    if (rst_n && (lo_we != we || lo_addr != addr || lo_stop != stop)) lo_mism <= lo_mism + 1;

  adc_capture_ctrl #(.DATA_W(DW), .ADDR_W(AW), .LEN_SMALL(L_S), .LEN_MID(L_M),
                     .LEN_LARGE(L_L), .TRIG_ACTIVE_HIGH(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cnt_run_i(cnt_run), .len_sel_i(len_sel),
    .trig_i(trig), .adc_rdy_i(rdy), .adc_data_i(adc_data), .adc_oe_o(adc_oe),
    .adc_pwr_o(adc_pwr), .sram_cs_o(cs), .sram_we_o(we), .sram_oe_o(oe),
    .sram_addr_o(addr), .sram_wdata_o(wdata), .sram_rdata_i(rdata),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data), .stop_o(stop));

  // R6: active-low build fed the inverted trigger
  adc_capture_ctrl #(.DATA_W(DW), .ADDR_W(AW), .LEN_SMALL(L_S), .LEN_MID(L_M),
                     .LEN_LARGE(L_L), .TRIG_ACTIVE_HIGH(1'b0)) dut_lo_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cnt_run_i(cnt_run), .len_sel_i(len_sel),
    .trig_i(~trig), .adc_rdy_i(rdy), .adc_data_i(adc_data), .adc_oe_o(lo_oe),
    .adc_pwr_o(lo_pwr), .sram_cs_o(lo_cs), .sram_we_o(lo_we), .sram_oe_o(lo_soe),
    .sram_addr_o(lo_addr), .sram_wdata_o(lo_wdata), .sram_rdata_i(rdata),
    .rd_valid_o(lo_valid), .rd_ready_i(rd_ready), .rd_data_o(lo_rd_data), .stop_o(lo_stop));

  function automatic int len_of(input logic [1:0] sel);
    return (sel == 2'd0) ? L_S : (sel == 2'd1) ? L_M : L_L;
  endfunction

  function automatic logic [3:0] ctl_of(input logic [1:0] m);
    case (m)
      2'd1:    return 4'b1100;
      2'd2:    return 4'b0011;
      2'd3:    return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic strobe(input logic [DW-1:0] d);
    @(negedge clk); adc_data = d; rdy = 1'b1;
    repeat (3) @(negedge clk);
    rdy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); cnt_run = 1'b0;
    repeat (2) @(negedge clk);
    cnt_run = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_trig(input logic v);
    @(negedge clk); trig = v;
    repeat (3) @(negedge clk);
  endtask

  // capture with a trigger gap over strobes 3..5; returns accepted count
  task automatic run_capture(input logic [1:0] sel, input int nstr, output int n_acc);
    int base;
    int lim;
    mode = 2'd1; len_sel = sel; lim = len_of(sel);
    set_trig(1'b1);
    restart();
    base = wr_count; n_acc = 0;
    for (int i = 0; i < nstr; i++) begin
      logic [DW-1:0] d;
      d = DW'($urandom);
      if (i == 0) d = 16'h7FFF;
      if (i == 1) d = 16'h8000;
      if (i == 3) set_trig(1'b0);
      if (i == 6) set_trig(1'b1);
      strobe(d);
      if (trig && n_acc < lim) begin exp_q[n_acc] = d; n_acc++; end
    end
    check("R3 write count", wr_count - base, n_acc);
    check("R5 stop at length", int'(stop), int'(n_acc == lim));
    check("R3 address after capture", int'(addr), n_acc % (1 << AW));
  endtask

  task automatic run_readback(input logic [1:0] sel, input int n);
    int bad;
    bad = 0;
    mode = 2'd2; len_sel = sel;
    restart();
    for (int k = 0; k < n; k++) begin
      int w;
      w = int'($urandom_range(0, 3));
      for (int j = 0; j < w; j++) begin
        @(negedge clk);
        if (!rd_valid || rd_data != exp_q[k]) bad++;
      end
      if (k < 2 || k == n - 1) begin
        check("R8 valid during read-back", int'(rd_valid), 1);
        check("R10 read-back word", int'(rd_data), int'(exp_q[k]));
      end else if (!rd_valid || rd_data != exp_q[k]) bad++;
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    check("R8 words held under back-pressure", bad, 0);
    check("R8 valid drops at length", int'(rd_valid), 0);
    check("R8 address at end", int'(addr), n % (1 << AW));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n_acc;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 stop", int'(stop), 0);
    check("R1 we", int'(we), 0);
    check("R1 valid", int'(rd_valid), 0);
    check("R1 addr", int'(addr), 0);

    // R2
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); mode = 2'(m);
      @(negedge clk);
      check("R2 mode controls", int'({adc_oe, adc_pwr, oe, cs}), int'(ctl_of(2'(m))));
    end

    // R9 / R10 direct path
    mode = 2'd3;
    @(negedge clk);
    check("R9 no valid before strobe", int'(rd_valid), 0);
    strobe(16'h8000);
    check("R9 valid after strobe", int'(rd_valid), 1);
    check("R10 direct negative full scale", int'(rd_data), 16'h8000);
    repeat (3) @(negedge clk);
    check("R9 held without ready", int'(rd_valid), 1);
    strobe(16'h7FFF);
    check("R10 direct latest sample", int'(rd_data), 16'h7FFF);
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    check("R9 consumed by handshake", int'(rd_valid), 0);

    // R4 clear mid capture
    mode = 2'd1; len_sel = 2'd1;
    set_trig(1'b1);
    restart();
    for (int i = 0; i < 5; i++) strobe(DW'($urandom));
    check("R3 partial address", int'(addr), 5);
    @(negedge clk); cnt_run = 1'b0;
    @(negedge clk);
    check("R4 address cleared", int'(addr), 0);
    check("R4 stop clear", int'(stop), 0);

    // small length, overfilled
    run_capture(2'd0, 14, n_acc);
    for (int i = 0; i < 2; i++) strobe(DW'($urandom));
    set_trig(1'b0);
    strobe(16'h1234);
    check("R7 stop held", int'(stop), 1);
    check("R5 no write past length", int'(addr), L_S);
    run_readback(2'd0, n_acc);

    run_capture(2'd1, 38, n_acc);
    run_readback(2'd1, n_acc);

    run_capture(2'd3, 70, n_acc);
    run_readback(2'd2, n_acc);

    check("R6 polarity variants agree", lo_mism, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule